// File: doc/BRIEF.md
# Carry-Save Iterative Multiplier with Early Exit

This block multiplies two 32-bit operands over several clock cycles and returns the low 32 bits of the product. It can optionally add a third operand to the product (multiply-accumulate). The partial result is kept as two words, a sum word and a carry word, and is not resolved while the iterations run. Each iteration is one clock. In that clock, four carry-save layers each fold two multiplier bits into the sum and carry words, so eight multiplier bits are consumed per clock. The multiplier register shifts right by eight bits per iteration and the multiplicand shifts left by eight bits. The unit stops as soon as the multiplier register holds no more ones. A single carry-propagate adder then merges the sum and carry words into the result.

A client drives `start_i` together with the operands while the unit is idle. It then waits for the one-cycle `done_o` pulse. In that cycle, `result_o` and the two flags `neg_o` and `zero_o` are valid. Small multipliers finish sooner than large ones. The number of iterations depends only on the position of the most significant non-zero byte of the multiplier operand.

Top module: `mulcs_unit`

## Requirements
- R1: With `acc_en_i` low, the result presented while `done_o` is high equals bits [31:0] of `op_a_i` × `op_b_i`, both taken as unsigned. The upper product bits are dropped.
- R2: With `acc_en_i` high, the result equals bits [31:0] of `op_a_i` × `op_b_i` + `acc_i`.
- R3: Let n be the index of the most significant non-zero byte of `op_b_i` plus one, where byte 0 is bits [7:0], and let n be 0 when `op_b_i` is zero. Count the rising edge that samples `start_i` as edge 1. Then `done_o` is high exactly in the cycle after edge n+1, and low in every other cycle of the operation.
- R4: No operation takes more than four iterations. A multiplier with a non-zero top byte (bits [31:24]) gives `done_o` after edge 5.
- R5: `done_o` is high for exactly one cycle. The unit is idle on the following edge and accepts a new `start_i` from then on.
- R6: A `start_i` that arrives while an operation is in progress is ignored. The running operation finishes with its own operands and timing.
- R7: While `done_o` is high, `neg_o` equals bit 31 of the result, and `zero_o` is high exactly when the result is zero.
- R8: A zero multiplier gives `done_o` after the first edge. The result is then `acc_i` when `acc_en_i` is high, and 0 when it is low.
- R9: Two's-complement operands give the correct low 32 bits of the signed product, because the low half does not depend on signedness.
- R10: While `rst` is high, and in the cycle after it is released, `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation; accepted only when idle |
| op_a_i | input | 32 | Multiplicand |
| op_b_i | input | 32 | Multiplier; its highest non-zero byte sets the iteration count |
| acc_i | input | 32 | Addend for multiply-accumulate |
| acc_en_i | input | 1 | High selects multiply-accumulate, low selects plain multiply |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 32 | Low 32 bits of the product or product plus addend |
| neg_o | output | 1 | Sign of the result, valid with done_o |
| zero_o | output | 1 | High when the result is zero, valid with done_o |

## Verification
The most likely internal faults are a misaligned multiplicand shift, a wrong carry shift in a layer, and a bad accumulator load. Each of these corrupts `result_o` on the very `done_o` pulse of the affected operation, so the bench compares every result with an arithmetic model. A fault in the early-exit test or in the iteration count moves `done_o` by one or more cycles. To catch this, the model predicts the expected `done_o` level in every cycle from the byte position of the multiplier, and the bench compares it cycle by cycle. Random operands are masked to one to four bytes, so that every iteration count and the zero case all occur.

// File: rtl/mulcs_pkg.sv
package mulcs_pkg;

    // Default geometry: operand width, multiplier bits per layer, layer count
    localparam int unsigned OP_W        = 32;
    localparam int unsigned LAYER_BITS  = 2;
    localparam int unsigned LAYER_COUNT = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;

endpackage

// File: rtl/mulcs_layer.sv
// One carry-save layer: folds BPL multiplier bits into the redundant pair.
module mulcs_layer #(
    parameter int unsigned W    = mulcs_pkg::OP_W,
    parameter int unsigned BPL  = mulcs_pkg::LAYER_BITS,
    parameter int unsigned BASE = 0
) (
    input  logic [W-1:0]   sum_i,
    input  logic [W-1:0]   carry_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [BPL-1:0] bits_i,
    output logic [W-1:0]   sum_o,
    output logic [W-1:0]   carry_o
);
    for (genvar k = 0; k < BPL; k++) begin : row
        logic [W-1:0] s_in, c_in, addend, s_out, c_out;
        if (k == 0) begin : g_first
            assign s_in = sum_i;
            assign c_in = carry_i;
        end else begin : g_next
            assign s_in = row[k-1].s_out;
            assign c_in = row[k-1].c_out;
        end
        // Partial product for this multiplier bit, aligned to its weight
        assign addend = bits_i[k] ? (mcand_i << (BASE + k)) : '0;
        // 3:2 compression, carries move one place up, overflow discarded
        assign s_out  = s_in ^ c_in ^ addend;
        assign c_out  = ((s_in & c_in) | (s_in & addend) | (c_in & addend)) << 1;
    end

    assign sum_o   = row[BPL-1].s_out;
    assign carry_o = row[BPL-1].c_out;
endmodule

// File: rtl/mulcs_array.sv
// Chain of carry-save layers consuming BPL*LAYERS multiplier bits per pass.
module mulcs_array #(
    parameter int unsigned W      = mulcs_pkg::OP_W,
    parameter int unsigned BPL    = mulcs_pkg::LAYER_BITS,
    parameter int unsigned LAYERS = mulcs_pkg::LAYER_COUNT,
    localparam int unsigned STEP  = BPL * LAYERS
) (
    input  logic [W-1:0]    sum_i,
    input  logic [W-1:0]    carry_i,
    input  logic [W-1:0]    mcand_i,
    input  logic [STEP-1:0] bits_i,
    output logic [W-1:0]    sum_o,
    output logic [W-1:0]    carry_o
);
    for (genvar l = 0; l < LAYERS; l++) begin : lyr
        logic [W-1:0] s_in, c_in, s_out, c_out;
        if (l == 0) begin : g_first
            assign s_in = sum_i;
            assign c_in = carry_i;
        end else begin : g_next
            assign s_in = lyr[l-1].s_out;
            assign c_in = lyr[l-1].c_out;
        end
        mulcs_layer #(.W(W), .BPL(BPL), .BASE(l * BPL)) u_layer (
            .sum_i   (s_in),
            .carry_i (c_in),
            .mcand_i (mcand_i),
            .bits_i  (bits_i[l*BPL +: BPL]),
            .sum_o   (s_out),
            .carry_o (c_out)
        );
    end

    assign sum_o   = lyr[LAYERS-1].s_out;
    assign carry_o = lyr[LAYERS-1].c_out;
endmodule

// File: rtl/mulcs_resolve.sv
// Final carry-propagate add of the redundant pair, plus sign and zero flags.
module mulcs_resolve #(
    parameter int unsigned W = mulcs_pkg::OP_W
) (
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] value_o,
    output logic         neg_o,
    output logic         zero_o
);
    always_comb begin
        value_o = sum_i + carry_i;
        neg_o   = value_o[W-1];
        zero_o  = (value_o == '0);
    end
endmodule

// File: rtl/mulcs_unit.sv
// Iterative multiply / multiply-accumulate with early exit on an empty multiplier.
module mulcs_unit
    import mulcs_pkg::*;
#(
    parameter int unsigned W      = mulcs_pkg::OP_W,
    parameter int unsigned BPL    = mulcs_pkg::LAYER_BITS,
    parameter int unsigned LAYERS = mulcs_pkg::LAYER_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic [W-1:0] acc_i,
    input  logic         acc_en_i,
    output logic         done_o,
    output logic [W-1:0] result_o,
    output logic         neg_o,
    output logic         zero_o
);
    localparam int unsigned STEP     = BPL * LAYERS;
    localparam int unsigned MAX_ITER = (W + STEP - 1) / STEP;
    localparam int unsigned ITER_W   = $clog2(MAX_ITER + 1);

    mul_state_e  state_q;
    logic [W-1:0] psum_q, pcarry_q, mcand_q, mplier_q;
    logic [ITER_W-1:0] iter_q;

    logic [W-1:0] psum_d, pcarry_d, mplier_shift, mcand_shift;

    assign mplier_shift = mplier_q >> STEP;
    assign mcand_shift  = mcand_q << STEP;

    mulcs_array #(.W(W), .BPL(BPL), .LAYERS(LAYERS)) u_array (
        .sum_i   (psum_q),
        .carry_i (pcarry_q),
        .mcand_i (mcand_q),
        .bits_i  (mplier_q[STEP-1:0]),
        .sum_o   (psum_d),
        .carry_o (pcarry_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            psum_q   <= '0;
            pcarry_q <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            iter_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        // Redundant pair starts out holding the addend (or zero)
                        psum_q   <= acc_en_i ? acc_i : '0;
                        pcarry_q <= '0;
                        mcand_q  <= op_a_i;
                        mplier_q <= op_b_i;
                        iter_q   <= '0;
                        state_q  <= (op_b_i == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    psum_q   <= psum_d;
                    pcarry_q <= pcarry_d;
                    mcand_q  <= mcand_shift;
                    mplier_q <= mplier_shift;
                    iter_q   <= iter_q + ITER_W'(1);
                    state_q  <= (mplier_shift == '0) ? ST_FIN : ST_RUN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mulcs_resolve #(.W(W)) u_resolve (
        .sum_i   (psum_q),
        .carry_i (pcarry_q),
        .value_o (result_o),
        .neg_o   (neg_o),
        .zero_o  (zero_o)
    );

    assign done_o = (state_q == ST_FIN);

    // R5: completion is a single-cycle pulse followed by idle
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_then_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (state_q == ST_IDLE));
    // R4: iteration count stays within the bound
    p_iter_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (iter_q < ITER_W'(MAX_ITER)));
    // R3: iterating only while multiplier bits remain
    p_run_live_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN) |-> (mplier_q != '0));
    // R8: zero multiplier finishes on the next cycle
    p_zero_mult_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_IDLE) && start_i && (op_b_i == '0)) |=> done_o);
    // R6: a start while running never drops the operation back to idle
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RUN) && start_i) |=> (state_q != ST_IDLE));
endmodule

// File: tb/mulcs_unit_test.sv
module mulcs_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        acc_en = 1'b0;
    logic [31:0] a = '0, b = '0, acc = '0;
    logic        done, neg, zero;
    logic [31:0] res;

    int    checks = 0, errors = 0, cycles = 0;
    int    m_state = 0, m_wait = 0;
    logic [31:0] m_res = '0;
    string m_tag = "R1";
    string cur_tag = "R1";
    bit    rst_prev = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulcs_unit uut (
        .clk(clk), .rst(rst), .start_i(start), .op_a_i(a), .op_b_i(b),
        .acc_i(acc), .acc_en_i(acc_en), .done_o(done), .result_o(res),
        .neg_o(neg), .zero_o(zero)
    );

    function automatic int active_bytes(logic [31:0] v);
        for (int i = 3; i >= 0; i--) if (v[8*i +: 8] != 8'h00) return i + 1;
        return 0;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    // Behavioural reference: compare, then step for the coming edge
    always @(negedge clk) begin
        cycles++;
        check(done == (m_state == 2), (rst || rst_prev) ? "R10" : "R3", "done level",
              {31'b0, done}, {31'b0, (m_state == 2)});
        if (m_state == 2 && done) begin
            check(res == m_res, m_tag, "result", res, m_res);
            check(neg == m_res[31], "R7", "neg flag", {31'b0, neg}, {31'b0, m_res[31]});
            check(zero == (m_res == 0), "R7", "zero flag", {31'b0, zero}, {31'b0, (m_res == 0)});
        end
        rst_prev = rst;
        if (rst) begin
            m_state = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    logic [63:0] p;
                    p = {32'b0, a} * {32'b0, b} + (acc_en ? {32'b0, acc} : 64'b0);
                    m_res = p[31:0];
                    m_tag = cur_tag;
                    m_wait = active_bytes(b);
                    m_state = (m_wait == 0) ? 2 : 1;
                end
                1: begin
                    m_wait--;
                    if (m_wait == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_op(logic [31:0] xa, logic [31:0] xb, logic [31:0] xacc, bit xen, string tag);
        @(posedge clk); #1;
        cur_tag = tag; a = xa; b = xb; acc = xacc; acc_en = xen; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 / R3: plain multiply, one to four active bytes
        run_op(32'd7, 32'd6, 32'd0, 1'b0, "R1");
        run_op(32'h0001_2345, 32'h0000_0101, 32'd0, 1'b0, "R1");
        run_op(32'h1234_5678, 32'h0001_0000, 32'd0, 1'b0, "R1");
        // R4: top byte set, longest run
        run_op(32'hDEAD_BEEF, 32'hFF00_0000, 32'd0, 1'b0, "R4");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0, "R4");
        // R2: accumulate
        run_op(32'd100, 32'd3, 32'd11, 1'b1, "R2");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R2");
        // R8: zero multiplier with and without addend
        run_op(32'h1234_5678, 32'd0, 32'hCAFE_F00D, 1'b0, "R8");
        run_op(32'h1234_5678, 32'd0, 32'hCAFE_F00D, 1'b1, "R8");
        // R9: signed operands, R7 negative result
        run_op(-32'sd3, 32'd5, 32'd0, 1'b0, "R9");
        run_op(-32'sd7, -32'sd9, 32'd0, 1'b0, "R9");
        run_op(32'd4, -32'sd1, 32'd4, 1'b1, "R9");
        // R6: start held while busy with other operands
        @(posedge clk); #1;
        cur_tag = "R6"; a = 32'd3; b = 32'h0100_0000; acc = 32'd0; acc_en = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        a = 32'h5555_5555; b = 32'd9; acc = 32'd77; acc_en = 1'b1;
        repeat (2) @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        // R5: back-to-back operations straight after done
        run_op(32'd9, 32'd9, 32'd0, 1'b0, "R5");
        run_op(32'd2, 32'd0, 32'd0, 1'b0, "R5");
        // Random mix over all byte counts
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb, rc;
            int nb;
            ra = $urandom; rb = $urandom; rc = $urandom; nb = $urandom_range(0, 4);
            rb = (nb == 0) ? 32'd0 : (rb & (32'hFFFF_FFFF >> (8 * (4 - nb))));
            run_op(ra, rb, rc, 1'($urandom_range(0, 1)), "R2");
        end
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule